// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is a target on a two-wire serial bus (I2C protocol) that gives a bus controller access to an 8192-byte memory inside the block. A system clock much faster than the bus clock oversamples the clock and data lines. The block finds start and stop conditions on the bus and answers only to its own target address. It pulls the data line low through an output enable and never drives it high.

A write transfer carries a two-byte memory address and then any number of data bytes. Each data byte is stored as soon as its eighth bit has arrived, so the block never needs busy time. An address latch inside the block steps after every byte that is written or sent. A read transfer with no address phase starts from wherever the latch points. To read from a chosen location, the controller sends a write transfer that holds only the two address bytes, then a repeated start with a read address byte. A lock input makes the whole array read-only, but it does not change how the block responds on the bus.

Top module: `twm_target`

## Requirements
- R1: The first byte after a start is the target address: bits 7..4 must be 1010 and bits 3..1 must equal `sel_strap`, and bit 0 set to 1 means read. On a match the block acknowledges. On any other value it does not acknowledge and leaves the data line released until the next start.
- R2: A write transfer sends the high address byte and then the low address byte. Bits 7..5 of the high byte are ignored. Every address byte and data byte is acknowledged, each data byte is stored at the latch, and the latch then increments.
- R3: While `wr_lock` is high, data bytes are still acknowledged and the latch still steps, but no memory location changes.
- R4: A read with no address phase returns the byte at the current latch value. The latch increments after every byte sent, including the last byte, which the controller does not acknowledge.
- R5: An address-only write followed by a repeated start and a read address byte returns data starting at the loaded address.
- R6: When the controller acknowledges a read byte, the next sequential byte follows. When it does not, the block releases the data line and ignores further clock pulses until a start or stop. Those pulses do not move the latch.
- R7: The latch wraps from 0x1FFF to 0x0000 on both writes and reads.
- R8: A byte is stored in the system cycle right after it is received, so a read issued right after the stop returns the new value.
- R9: `sda_oe` changes only while the synchronized clock line is low, except when it releases on a start or stop condition.
- R10: Reset releases the data line and sets the latch to 0x0000. The memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sel_strap | input | 3 | Strap value the target address select bits must equal |
| wr_lock | input | 1 | High makes the whole array read-only |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
Two events can land in the same system cycle: the array write of a received byte, and the read port fetching the word the stepped latch now points to. Both use the same 64-bit storage word whenever the next address is in the same lane group. The bench provokes this by writing one byte at 0x0103 and then, with no address phase, reading the neighbour 0x0104. The neighbour must come back with its earlier value, and the written byte must read back correctly afterwards. A second pairing is a stop followed at once by a selective read of the byte just written. This is judged on the returned value with no idle gap between the two transfers.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/twm_bus_sync.sv
module twm_bus_sync
    import twm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_s,
    output logic    sda_s,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_p;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= (chain << 1) | STAGES'(line_in[g]);
        end
        assign line_s[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) line_p <= '1;
        else     line_p <= line_s;
    end

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    always_comb begin
        ev.rise  = line_s[0] & ~line_p[0];
        ev.fall  = ~line_s[0] & line_p[0];
        ev.start = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
        ev.stop  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];
    end

endmodule

// File: rtl/twm_array.sv
module twm_array #(
    parameter int ADDR_W = 13,
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int WORD_AW = ADDR_W - LANE_W;
    localparam int WORDS   = 1 << WORD_AW;
    localparam int LANES   = 1 << LANE_W;
    localparam int WORD_W  = LANES * 8;

    logic [WORD_W-1:0] mem [WORDS];

    logic [WORD_AW-1:0] wr_word, rd_word;
    logic [LANE_W+2:0]  wr_bit, rd_bit;

    assign wr_word = wr_addr[ADDR_W-1:LANE_W];
    assign rd_word = rd_addr[ADDR_W-1:LANE_W];
    assign wr_bit  = {wr_addr[LANE_W-1:0], 3'b000};
    assign rd_bit  = {rd_addr[LANE_W-1:0], 3'b000};

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_word][wr_bit +: 8] <= wr_data;
        rd_data <= mem[rd_word][rd_bit +: 8];
    end

endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
    import twm_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [2:0]        sel,
    input  logic              wr_lock,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [3:0] BIT_LAST = 4'd8;
    localparam logic [3:0] BIT_ACK  = 4'd9;

    phase_t            phase;
    logic [3:0]        cnt;
    logic [7:0]        sh;
    logic [7:0]        hi;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              mack_q;
    logic [7:0]        tx_q;
    logic              oe_q;

    assign wr_en   = ev.fall && (cnt == BIT_LAST) && (phase == PH_WDAT) && !wr_lock;
    assign wr_addr = addr_q;
    assign wr_data = sh;
    assign rd_addr = addr_q;
    assign sda_oe  = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            sh     <= '0;
            hi     <= '0;
            addr_q <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            tx_q   <= '0;
            oe_q   <= 1'b0;
        end else if (ev.start) begin
            phase <= PH_DEV;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (ev.rise) begin
                if (cnt != BIT_ACK) cnt <= cnt + 4'd1;
                if (cnt < BIT_LAST && phase != PH_RDAT) sh <= {sh[6:0], sda_s};
                if (cnt == BIT_LAST && phase == PH_RDAT) begin
                    mack_q <= !sda_s;
                    addr_q <= addr_q + 1'b1;
                end
            end else if (ev.fall) begin
                if (cnt == BIT_LAST) begin
                    unique case (phase)
                        PH_DEV: begin
                            if (dev_match(sh, sel)) begin
                                oe_q <= 1'b1;
                                rw_q <= sh[0];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            oe_q <= 1'b1;
                            hi   <= sh;
                        end
                        PH_ALO: begin
                            oe_q   <= 1'b1;
                            addr_q <= ADDR_W'({hi, sh});
                        end
                        PH_WDAT: begin
                            oe_q   <= 1'b1;
                            addr_q <= addr_q + 1'b1;
                        end
                        default: oe_q <= 1'b0;
                    endcase
                end else if (cnt == BIT_ACK) begin
                    cnt  <= '0;
                    oe_q <= 1'b0;
                    unique case (phase)
                        PH_DEV: begin
                            if (rw_q) begin
                                phase <= PH_RDAT;
                                tx_q  <= rd_data;
                                oe_q  <= !rd_data[7];
                            end else begin
                                phase <= PH_AHI;
                            end
                        end
                        PH_AHI: phase <= PH_ALO;
                        PH_ALO: phase <= PH_WDAT;
                        PH_RDAT: begin
                            if (mack_q) begin
                                tx_q <= rd_data;
                                oe_q <= !rd_data[7];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end else if (phase == PH_RDAT) begin
                    oe_q <= !tx_q[6];
                    tx_q <= {tx_q[6:0], 1'b0};
                end
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> (!$past(scl_s) || $past(ev.start) || $past(ev.stop))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !oe_q); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_q) |-> ((addr_q == ADDR_W'($past(addr_q) + 1'b1)) || ($past(phase) == PH_ALO))); // R7

    AST_COMMIT_ACKED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> oe_q); // R2

endmodule

// File: rtl/twm_target.sv
module twm_target
    import twm_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int LANE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_strap,
    input  logic       wr_lock,
    output logic       sda_oe
);
    bus_ev_t           ev;
    logic              scl_s, sda_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [7:0]        wr_data, rd_data;

    twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (ev)
    );

    twm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .sel     (sel_strap),
        .wr_lock (wr_lock),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr)
    );

    twm_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_twm_target.sv
module tb_twm_target;

    localparam int T = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wr_lock = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  model [int];
    logic [12:0] exp_ptr = '0;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    twm_target dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sel_strap (strap),
        .wr_lock   (wr_lock),
        .sda_oe    (sda_oe)
    );

    // R9 monitor: output enable must not move while the clock is high and the data line is quiet
    int   hi_run = 0, sda_run = 0, r9_bad = 0;
    logic oe_prev = 1'b0, msda_prev = 1'b1;
    always @(negedge clk) begin
        if (scl) hi_run++; else hi_run = 0;
        if (m_sda == msda_prev) sda_run++; else sda_run = 0;
        if (!rst && sda_oe != oe_prev && hi_run >= 1 && sda_run >= 6) r9_bad++;
        oe_prev   = sda_oe;
        msda_prev = m_sda;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 13 + 7) ^ (i << 3));
    endfunction

    task automatic bus_start;
        m_sda = 1'b1; tick(T);
        scl   = 1'b1; tick(T);
        m_sda = 1'b0; tick(T);
        scl   = 1'b0; tick(T);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(T);
        scl   = 1'b1; tick(T);
        m_sda = 1'b1; tick(2 * T);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(T);
            scl = 1'b1;   tick(2 * T);
            scl = 1'b0;   tick(T);
        end
        m_sda = 1'b1; tick(T);
        scl = 1'b1;   tick(T);
        ack = !sda_line;
        tick(T);
        scl = 1'b0;   tick(T);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(T);
            scl = 1'b1; tick(T);
            b = {b[6:0], sda_line};
            tick(T);
            scl = 1'b0; tick(T);
        end
        m_sda = !give_ack; tick(T);
        scl = 1'b1;        tick(2 * T);
        scl = 1'b0;        tick(T);
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input int seed, input string req);
        logic ack;
        int   acks;
        logic [7:0] d;
        acks = 0;
        bus_start;
        send_byte({4'b1010, strap, 1'b0}, ack); acks += int'(ack);
        send_byte(a[15:8], ack);                acks += int'(ack);
        send_byte(a[7:0], ack);                 acks += int'(ack);
        for (int i = 0; i < n; i++) begin
            d = pat(seed, i);
            send_byte(d, ack);
            acks += int'(ack);
            if (!wr_lock) model[int'(13'(a[12:0] + 13'(i)))] = d;
        end
        bus_stop;
        exp_ptr = 13'(a[12:0] + 13'(n));
        check(req, "write acks", acks, n + 3);
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            check(req, $sformatf("byte @%0h", exp_ptr), int'(b), int'(model[int'(exp_ptr)]));
            exp_ptr = exp_ptr + 13'd1;
        end
    endtask

    task automatic do_rd_cur(input int n, input string req);
        logic ack;
        bus_start;
        send_byte({4'b1010, strap, 1'b1}, ack);
        check(req, "read address ack", int'(ack), 1);
        read_bytes(n, req);
        bus_stop;
    endtask

    task automatic do_rd_sel(input logic [15:0] a, input int n, input string req);
        logic ack;
        int   acks;
        acks = 0;
        bus_start;
        send_byte({4'b1010, strap, 1'b0}, ack); acks += int'(ack);
        send_byte(a[15:8], ack);                acks += int'(ack);
        send_byte(a[7:0], ack);                 acks += int'(ack);
        bus_start;
        send_byte({4'b1010, strap, 1'b1}, ack); acks += int'(ack);
        check(req, "selective read acks", acks, 4);
        exp_ptr = a[12:0];
        read_bytes(n, req);
        bus_stop;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

    initial begin
        logic       ack;
        logic [7:0] b;

        tick(5);
        check("R10", "sda_oe in reset", int'(sda_oe), 0);
        rst = 1'b0;
        tick(5);
        check("R10", "sda_oe after reset", int'(sda_oe), 0);

        // R1: sweep every select value, plus a wrong device code
        for (int s = 0; s < 8; s++) begin
            bus_start;
            send_byte({4'b1010, 3'(s), 1'b0}, ack);
            check("R1", $sformatf("ack for select %0d", s), int'(ack), int'(3'(s) == strap));
            if (3'(s) != strap) begin
                send_byte(8'h00, ack);
                check("R1", "silent after mismatch", int'(ack), 0);
            end
            bus_stop;
        end
        bus_start;
        send_byte({4'b1011, strap, 1'b0}, ack);
        check("R1", "wrong device code", int'(ack), 0);
        bus_stop;

        // R2 / R5: fill one word, read it back selectively
        do_write(16'h0000, 8, 1, "R2");
        do_rd_sel(16'h0000, 8, "R5");

        // R10: latch returns to zero, memory kept
        rst = 1'b1; tick(3); rst = 1'b0; tick(3);
        exp_ptr = '0;
        do_rd_cur(1, "R10");
        do_rd_cur(3, "R4");

        // R2 / R8: single bytes with garbage upper bits, read right after the stop
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a;
            a = {3'(k), 13'(16'h0200 + k * 9)};
            do_write(a, 1, 20 + k, "R2");
            do_rd_sel(a, 1, "R8");
        end

        // R7: write and read across the top of the array
        do_write(16'h1FFC, 8, 3, "R7");
        do_rd_sel(16'h1FFD, 6, "R7");
        do_rd_cur(1, "R4");

        // R3: locked write is acked, advances latch, leaves memory alone
        wr_lock = 1'b1;
        do_write(16'h0000, 4, 9, "R3");
        check("R3", "latch after locked write", int'(exp_ptr), 4);
        do_rd_cur(1, "R3");
        wr_lock = 1'b0;
        do_rd_sel(16'h0000, 4, "R3");

        // R6: NACK releases the bus; extra clocks are ignored
        do_rd_sel(16'h0000, 1, "R6");
        recv_byte(1'b0, b);
        check("R6", "released after nack", int'(b), 8'hFF);
        bus_stop;
        do_rd_cur(1, "R6");

        // R6: long sequential read
        do_write(16'h0100, 16, 5, "R2");
        do_rd_sel(16'h0100, 16, "R6");

        // R8: write a byte, then read its neighbour in the same word
        do_write(16'h0103, 1, 44, "R8");
        do_rd_cur(1, "R8");
        do_rd_sel(16'h0103, 1, "R8");

        check("R9", "sda_oe moves with clock high", r9_bad, 0);
        finish_run;
    end

endmodule